// File: doc/BRIEF.md
# USB Bit-Timing Recovery Loop

This block generates the timing strobes that a USB low-speed or full-speed receiver needs to sample its classified line state. Once a start-of-packet edge has been flagged, it raises a mid-bit sample strobe once per bit. It also raises an expected-edge strobe half a bit period before each sample point. The bit period is held as a count of sample-clock cycles in fixed point with 8 fractional bits, so a period that is not a whole number of cycles still keeps its average rate.

The loop follows the transmitter's clock. After each decoded zero bit, which is a line transition, it compares the line state captured at the expected-edge point with the newly sampled state. From that comparison it either shortens the period slightly and pulls the sample point earlier, or lengthens the period and pushes the sample point later. The period is reloaded with its nominal value at every start of packet and is kept within a ±2% band around that value.

The surrounding receiver classifies the line into symbols, spots the start-of-packet edge, and tells the loop whether the bit just sampled was a zero. Destuffing and packet framing are done elsewhere.

Top module: `usb_bit_timing_rec`

## Requirements
- R1: After reset, and until the first start-of-packet pulse, neither strobe is raised, whatever the other inputs do.
- R2: A start-of-packet pulse in cycle n makes the first sample strobe appear in cycle n + floor((128 + P/2)/256), where P is the nominal period in 1/256 cycle. At the default 48 MHz sample clock, this is n+2 in full-speed mode and n+16 in low-speed mode.
- R3: Each later sample target lies one current period (Q8) after the previous target, shifted by any phase correction. The edge strobe appears in the cycle given by the integer part of (new target − new period/2). The two strobes never coincide, and each edge strobe lasts a single cycle.
- R4: The period and the phase change only in a cycle where the sample strobe is high and zero_bit_i is high. zero_bit_i in any other cycle has no effect.
- R5: When an adjustment occurs and the edge-point line equals the current line (early), the period becomes P − (P>>10) and the next target moves earlier by (P'>>7)+(P'>>9), where P' is the new, clamped period. Otherwise (late), the period becomes P + (P>>10) and the target moves later by the same amount.
- R6: Line codes are 2'b00 SE0, 2'b01 J, 2'b10 K and 2'b11 SE1. No adjustment is made when the edge-point line is SE0 or SE1.
- R7: At each start of packet the period reloads to its nominal value. Adjustments are clamped to [N − N/50, N + N/50], where N is the nominal of the latched speed.
- R8: speed_i (1 = full speed 12 Mb/s, 0 = low speed 1.5 Mb/s) is taken only in the start-of-packet cycle. Changes between starts of packet are ignored.
- R9: The edge-point line is the line state captured in the edge-strobe cycle. For the first bit of a packet, it is the line state in the start-of-packet cycle.
- R10: A start-of-packet pulse while the loop is running restarts the timing as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 2 | Classified line state (SE0/J/K/SE1 codes of R6) |
| sop_i | input | 1 | Start-of-packet pulse, high in the cycle the J-to-K edge is seen |
| zero_bit_i | input | 1 | Bit sampled in this strobe cycle decoded as zero |
| speed_i | input | 1 | Speed mode, 1 = full speed, 0 = low speed |
| sample_stb_o | output | 1 | Mid-bit sample strobe |
| edge_stb_o | output | 1 | Expected-edge strobe |

## Verification
The bench builds the block with its defaults: a 48 MHz sample clock, a 16-bit Q8 period and adaptation enabled. This gives nominal periods of exactly 4 and 32 cycles, so each bit spans only a handful of cycles. Transmitters that run up to 1.5% fast or slow, constant lines that drive the period into its clamp, injected SE0 bits and mid-packet restarts can therefore all be driven through thousands of bits in a short run. A fixed-point model written from the requirements predicts both strobes in every cycle.

// File: rtl/usb_btr_pkg.sv
package usb_btr_pkg;

   typedef enum logic [1:0] {
      LN_SE0 = 2'b00,
      LN_J   = 2'b01,
      LN_K   = 2'b10,
      LN_SE1 = 2'b11
   } line_e;

   localparam int FRAC_BITS = 8;
   localparam int ONE_Q     = 1 << FRAC_BITS;

   // True for a differential (J or K) line state.
   function automatic logic is_data(input logic [1:0] ln);
      return ln[1] ^ ln[0];
   endfunction

endpackage

// File: rtl/usb_btr_period.sv
module usb_btr_period #(
   parameter int PW     = 16,
   parameter int NOM_LS = 8192,
   parameter int NOM_FS = 1024,
   parameter bit ADAPT  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sop_i,
   input  logic          speed_i,
   input  logic          adj_req_i,
   input  logic          adj_early_i,
   output logic [PW-1:0] period_q,
   output logic [PW-1:0] period_nx
);

   localparam logic [PW-1:0] NOM_LS_Q = PW'(NOM_LS);
   localparam logic [PW-1:0] NOM_FS_Q = PW'(NOM_FS);
   localparam logic [PW:0]   LS_LO    = (PW+1)'(NOM_LS - NOM_LS / 50);
   localparam logic [PW:0]   LS_HI    = (PW+1)'(NOM_LS + NOM_LS / 50);
   localparam logic [PW:0]   FS_LO    = (PW+1)'(NOM_FS - NOM_FS / 50);
   localparam logic [PW:0]   FS_HI    = (PW+1)'(NOM_FS + NOM_FS / 50);

   if (NOM_LS + NOM_LS / 50 >= (1 << PW)) begin : g_chk_ls
      $error("low-speed period band does not fit PW");
   end
   if (NOM_FS + NOM_FS / 50 >= (1 << PW)) begin : g_chk_fs
      $error("full-speed period band does not fit PW");
   end

   logic          speed_q;
   logic [PW:0]   lo_sel, hi_sel;
   logic [PW-1:0] nom_in;

   assign lo_sel = speed_q ? FS_LO : LS_LO;
   assign hi_sel = speed_q ? FS_HI : LS_HI;
   assign nom_in = speed_i ? NOM_FS_Q : NOM_LS_Q;

   if (ADAPT) begin : g_adapt
      logic [PW:0] cur_w, step_w, trial_w, clamp_w;
      always_comb begin
         cur_w   = {1'b0, period_q};
         step_w  = cur_w >> 10;
         trial_w = adj_early_i ? (cur_w - step_w) : (cur_w + step_w);
         if (trial_w < lo_sel)      clamp_w = lo_sel;
         else if (trial_w > hi_sel) clamp_w = hi_sel;
         else                       clamp_w = trial_w;
         if (sop_i)          period_nx = nom_in;
         else if (adj_req_i) period_nx = clamp_w[PW-1:0];
         else                period_nx = period_q;
      end
   end else begin : g_fixed
      assign period_nx = sop_i ? nom_in : period_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= NOM_FS_Q;
         speed_q  <= 1'b1;
      end else begin
         period_q <= period_nx;
         if (sop_i) speed_q <= speed_i;
      end
   end

   p_period_band_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, period_q} >= lo_sel) && ({1'b0, period_q} <= hi_sel));

   p_period_reload_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      sop_i |=> period_q == ($past(speed_i) ? NOM_FS_Q : NOM_LS_Q));

   p_period_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!sop_i && !adj_req_i) |=> $stable(period_q));

endmodule

// File: rtl/usb_btr_judge.sv
module usb_btr_judge
   import usb_btr_pkg::*;
#(
   parameter int PW    = 16,
   parameter bit ADAPT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          line_i,
   input  logic                sop_i,
   input  logic                sample_stb_i,
   input  logic                edge_stb_i,
   input  logic                zero_bit_i,
   input  logic [PW-1:0]       period_nx,
   output logic                adj_req_o,
   output logic                adj_early_o,
   output logic signed [PW+1:0] step_o
);

   localparam int DW = PW + 2;

   logic [1:0]           eline_q;
   logic [PW-1:0]        mag;
   logic signed [DW-1:0] mag_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    eline_q <= LN_J;
      else if (sop_i || edge_stb_i)  eline_q <= line_i;
   end

   if (ADAPT) begin : g_adapt
      assign adj_req_o = sample_stb_i && zero_bit_i && is_data(eline_q);
   end else begin : g_fixed
      assign adj_req_o = 1'b0;
   end

   assign adj_early_o = (eline_q == line_i);
   assign mag         = (period_nx >> 7) + (period_nx >> 9);
   assign mag_s       = $signed({2'b00, mag});
   assign step_o      = !adj_req_o ? '0 : (adj_early_o ? -mag_s : mag_s);

   p_eline_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!sop_i && !edge_stb_i) |=> $stable(eline_q));

endmodule

// File: rtl/usb_btr_phase.sv
module usb_btr_phase #(
   parameter int PW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sop_i,
   input  logic [PW-1:0]        period_nx,
   input  logic signed [PW+1:0] step_i,
   output logic                 sample_stb_o,
   output logic                 edge_stb_o
);

   localparam int DW = PW + 2;
   localparam logic signed [DW-1:0] ONE_S  = DW'(256);
   localparam logic signed [DW-1:0] HALF_S = DW'(128);

   logic                 run_q, arm_q;
   logic signed [DW-1:0] dist_q, edist_q;
   logic signed [DW-1:0] per_s, half_s, base_s;

   assign per_s  = $signed({2'b00, period_nx});
   assign half_s = $signed({3'b000, period_nx[PW-1:1]});
   assign base_s = dist_q + step_i - ONE_S;

   assign sample_stb_o = run_q && (dist_q < ONE_S);
   assign edge_stb_o   = run_q && arm_q && (edist_q < ONE_S);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         arm_q   <= 1'b0;
         dist_q  <= '0;
         edist_q <= '0;
      end else if (sop_i) begin
         run_q   <= 1'b1;
         arm_q   <= 1'b0;
         dist_q  <= HALF_S + half_s - ONE_S;
         edist_q <= '0;
      end else if (run_q) begin
         if (sample_stb_o) begin
            dist_q  <= base_s + per_s;
            edist_q <= base_s + half_s;
            arm_q   <= 1'b1;
         end else begin
            dist_q  <= dist_q - ONE_S;
            edist_q <= edist_q - ONE_S;
            if (edge_stb_o) arm_q <= 1'b0;
         end
      end
   end

   p_sop_quiet_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      sop_i |=> !sample_stb_o);

   p_edge_once_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      edge_stb_o |=> !edge_stb_o);

   p_idle_quiet_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> (!sample_stb_o && !edge_stb_o));

endmodule

// File: rtl/usb_bit_timing_rec.sv
module usb_bit_timing_rec #(
   parameter int SAMPLE_HZ = 48_000_000,
   parameter int FS_BPS    = 12_000_000,
   parameter int LS_BPS    = 1_500_000,
   parameter int PW        = 16,
   parameter bit ADAPT     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line_i,
   input  logic       sop_i,
   input  logic       zero_bit_i,
   input  logic       speed_i,
   output logic       sample_stb_o,
   output logic       edge_stb_o
);

   localparam longint NOM_FS_L = (longint'(SAMPLE_HZ) * 256) / longint'(FS_BPS);
   localparam longint NOM_LS_L = (longint'(SAMPLE_HZ) * 256) / longint'(LS_BPS);
   localparam int     NOM_FS   = int'(NOM_FS_L);
   localparam int     NOM_LS   = int'(NOM_LS_L);

   if (NOM_FS < 768 || NOM_LS < 768) begin : g_chk_rate
      $error("sample clock must give at least 3 cycles per bit");
   end

   logic [PW-1:0]        period_q, period_nx;
   logic                 adj_req, adj_early;
   logic signed [PW+1:0] step;

   usb_btr_period #(
      .PW(PW), .NOM_LS(NOM_LS), .NOM_FS(NOM_FS), .ADAPT(ADAPT)
   ) u_period (
      .clk(clk), .rst_n(rst_n), .sop_i(sop_i), .speed_i(speed_i),
      .adj_req_i(adj_req), .adj_early_i(adj_early),
      .period_q(period_q), .period_nx(period_nx)
   );

   usb_btr_judge #(.PW(PW), .ADAPT(ADAPT)) u_judge (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .sop_i(sop_i),
      .sample_stb_i(sample_stb_o), .edge_stb_i(edge_stb_o),
      .zero_bit_i(zero_bit_i), .period_nx(period_nx),
      .adj_req_o(adj_req), .adj_early_o(adj_early), .step_o(step)
   );

   usb_btr_phase #(.PW(PW)) u_phase (
      .clk(clk), .rst_n(rst_n), .sop_i(sop_i), .period_nx(period_nx),
      .step_i(step), .sample_stb_o(sample_stb_o), .edge_stb_o(edge_stb_o)
   );

   p_strobe_excl_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb_o && edge_stb_o));

   p_adj_on_sample_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      adj_req |-> (sample_stb_o && zero_bit_i));

   logic unused_period;
   assign unused_period = ^period_q;

endmodule

// File: tb/usb_bit_timing_rec_tb.sv
module usb_bit_timing_rec_tb;

   localparam longint NFS = (longint'(48_000_000) * 256) / 12_000_000;
   localparam longint NLS = (longint'(48_000_000) * 256) / 1_500_000;
   localparam logic [1:0] C_SE0 = 2'b00, C_J = 2'b01, C_K = 2'b10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] line_i = C_J;
   logic sop_i = 1'b0, zero_bit_i = 1'b0, speed_i = 1'b1;
   logic sample_stb_o, edge_stb_o;

   always #10 clk = ~clk;

   usb_bit_timing_rec u_dut (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .sop_i(sop_i),
      .zero_bit_i(zero_bit_i), .speed_i(speed_i),
      .sample_stb_o(sample_stb_o), .edge_stb_o(edge_stb_o)
   );

   int vectors = 0, miscompares = 0, ncyc = 0;
   bit done = 1'b0;

   // fixed-point model of the requirements
   bit     m_run = 0, m_arm = 0, m_spd = 1;
   longint m_dist = 0, m_edist = 0, m_p = NFS;
   logic [1:0] m_eline = C_J;
   logic [15:0] lfsr = 16'hACE1;

   function automatic bit m_fire();
      return m_run && (m_dist < 256);
   endfunction
   function automatic bit m_edge();
      return m_run && m_arm && (m_edist < 256);
   endfunction

   task automatic lfsr_step();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic compare(input string tag);
      vectors++;
      if (sample_stb_o !== m_fire() || edge_stb_o !== m_edge()) begin
         miscompares++;
         $display("FAIL %s cycle %0d: sample=%b exp %b, edge=%b exp %b",
                  tag, ncyc, sample_stb_o, m_fire(), edge_stb_o, m_edge());
      end
   endtask

   task automatic model_step(input bit sop, input bit spd, input logic [1:0] ln, input bit zero);
      bit f, e;
      longint pn, ph, lo, hi, mag, base;
      f = m_fire();
      e = m_edge();
      if (sop) begin
         m_run = 1; m_spd = spd; m_p = spd ? NFS : NLS;
         m_dist = 128 + m_p / 2 - 256; m_arm = 0; m_edist = 0; m_eline = ln;
      end else if (m_run) begin
         if (f) begin
            pn = m_p; ph = 0;
            if (zero && (m_eline == C_J || m_eline == C_K)) begin
               lo = (m_spd ? NFS : NLS) - (m_spd ? NFS : NLS) / 50;
               hi = (m_spd ? NFS : NLS) + (m_spd ? NFS : NLS) / 50;
               pn = (m_eline == ln) ? m_p - (m_p >> 10) : m_p + (m_p >> 10);
               if (pn < lo) pn = lo;
               if (pn > hi) pn = hi;
               mag = (pn >> 7) + (pn >> 9);
               ph = (m_eline == ln) ? -mag : mag;
            end
            m_p = pn;
            base = m_dist + ph - 256;
            m_dist = base + pn;
            m_edist = base + pn / 2;
            m_arm = 1;
         end else begin
            if (e) begin m_eline = ln; m_arm = 0; end
            m_dist -= 256;
            m_edist -= 256;
         end
      end
   endtask

   // compare at this falling edge, drive inputs, advance model, wait a cycle
   task automatic tick(input bit sop, input bit spd, input logic [1:0] ln, input bit zero, input string tag);
      compare(tag);
      sop_i = sop; speed_i = spd; line_i = ln; zero_bit_i = zero;
      model_step(sop, spd, ln, zero);
      ncyc++;
      @(negedge clk);
   endtask

   // mode 0: device at pd_pm per-mille of nominal; 1: constant K with zero at
   // every sample; 2: device with SE0 bits; 3: random zero, speed and restarts
   task automatic scenario(input bit spd, input int pd_pm, input int mode, input int cycles);
      longint nom, pd, acc;
      logic [1:0] ln, prev;
      bit first_seen, zero, sopv, spdv;
      int since;
      nom = spd ? NFS : NLS;
      pd = nom * pd_pm / 1000;
      for (int i = 0; i < 4; i++) tick(0, spd, C_J, 0, "R1 R8 idle");
      ln = C_K; prev = C_K; acc = 0; first_seen = 0; since = 0;
      tick(1, spd, ln, 0, "R10 sop");
      for (int c = 0; c < cycles; c++) begin
         since++;
         if (!first_seen && sample_stb_o) begin
            first_seen = 1;
            vectors++;
            if (since != (128 + nom / 2) / 256) begin
               miscompares++;
               $display("FAIL R2 first sample after %0d cycles, expected %0d",
                        since, (128 + nom / 2) / 256);
            end
         end
         lfsr_step();
         acc += 256;
         if (acc >= pd && mode != 1) begin
            acc -= pd;
            if (mode == 2 && lfsr[6:0] < 7)       ln = C_SE0;
            else if (ln != C_J && ln != C_K)      ln = C_J;
            else if (!lfsr[3])                     ln = (ln == C_J) ? C_K : C_J;
         end
         sopv = 0; spdv = spd; zero = 0;
         if (mode == 3) begin
            spdv = lfsr[9];
            sopv = (lfsr[11:0] == 12'h5A5);
         end
         if (m_fire()) begin
            zero = (mode == 1) ? 1'b1 : (ln != prev);
            prev = ln;
         end else if (mode == 3) begin
            zero = lfsr[2];
         end
         if (sopv) begin ln = C_K; prev = C_K; spdv = spd; end
         tick(sopv, spdv, ln, zero, "R3 R4 R5 R6 R7 R8 R9 R10 strobes");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // reset held: outputs must be quiet
      vectors++;
      if (sample_stb_o !== 1'b0 || edge_stb_o !== 1'b0) begin
         miscompares++;
         $display("FAIL R1 in reset: sample=%b edge=%b expected 0 0", sample_stb_o, edge_stb_o);
      end
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 40; i++) begin
         lfsr_step();
         tick(0, lfsr[0], lfsr[2:1], lfsr[3], "R1 before sop");
      end
      scenario(1, 1000, 0, 2000);
      scenario(1, 1015, 0, 3000);
      scenario(1, 985, 0, 3000);
      scenario(1, 1000, 1, 1500);
      scenario(1, 1010, 2, 3000);
      scenario(1, 1000, 3, 6000);
      scenario(0, 1012, 0, 20000);
      scenario(0, 990, 1, 12000);
      scenario(0, 1000, 3, 20000);
      scenario(0, 988, 2, 15000);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog expired at cycle %0d", ncyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule